// File: doc/BRIEF.md
# Modem Control and Status Delta Unit

This block holds the modem control byte of a 16550-style serial port and produces the matching modem status byte. Software writes the control byte through a write strobe. The status byte is read through a read strobe. The status byte has four line-state bits in its upper nibble and four sticky change flags in its lower nibble. A single flag tells the interrupt logic that at least one change flag is set.

When the loopback bit of the control byte is set, the four control outputs drive the status line-state bits and the external inputs have no effect. When loopback is clear, the carrier-detect and data-set-ready bits read as asserted. Clear-to-send and ring-indicator then follow two external inputs, which are already active-high. These inputs pass through a resynchroniser whose depth is a parameter. Every cycle, the unit compares the current line state with the state it last sampled and records each change. A read of the status byte returns the value held at that moment and clears all four change flags at the same clock edge.

Top module: `modem_ctl_status`

## Requirements
- R1: A write stores bits 0 to 4 of the written byte in the control register, visible on `ctl_q` one cycle after the strobe. Bits 5 to 7 of `ctl_q` always read zero. Control bits are: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback.
- R2: After reset, `ctl_q` is 0x00, `sts_q` is 0xA0 (carrier detect and data-set-ready asserted, no change flags) and `sts_change` is low, provided the external inputs are low.
- R3: With the loopback bit set, the status line bits map from the control bits as follows: bit 4 (CTS) from RTS, bit 5 (DSR) from DTR, bit 6 (RI) from OUT1, and bit 7 (DCD) from OUT2. The external inputs are ignored.
- R4: With loopback clear, status bits 7 (DCD) and 5 (DSR) read 1. Bit 4 follows `modem_cts_i` and bit 6 follows `modem_ri_i`, each after SYNC_STAGES+1 cycles.
- R5: A change in either direction of CTS, DSR or DCD sets change flag bit 0, bit 1 or bit 3 respectively.
- R6: Change flag bit 2 is set when RI goes from 1 to 0. It is not set when RI goes from 0 to 1.
- R7: Change flags stay set until a read, while the line-state bits keep tracking the lines.
- R8: During a read strobe, `sts_q` shows the value held before the read. At that clock edge all four change flags clear, except that a change detected at the same edge still sets its flag.
- R9: `sts_change` is high exactly when any of status bits 0 to 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control write byte |
| ctl_q | output | 8 | Control register value |
| sts_rd_en | input | 1 | Status read strobe, clears change flags |
| sts_q | output | 8 | Status byte: line bits 7..4, change flags 3..0 |
| sts_change | output | 1 | Any change flag set |
| modem_cts_i | input | 1 | External clear-to-send, active high |
| modem_ri_i | input | 1 | External ring indicator, active high |

## Verification
The in-line properties cover the behaviours that can be checked every cycle:
- masking of the control byte;
- the loopback mapping one cycle after a control value is held;
- the forced carrier and data-set-ready bits outside loopback;
- the rule that a rising RI sets no flag while a falling RI does;
- flag persistence without a read;
- clearing on a quiet read.

The scenarios in the bench show the remaining behaviours:
- the combined effect of several line changes on the flag pattern;
- that external inputs are ignored during loopback;
- the latency of the resynchroniser;
- a change that coincides with a read.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_LINES = 4;

  // control byte fields
  localparam int unsigned CTL_DTR  = 0;
  localparam int unsigned CTL_RTS  = 1;
  localparam int unsigned CTL_OUT1 = 2;
  localparam int unsigned CTL_OUT2 = 3;
  localparam int unsigned CTL_LOOP = 4;
  localparam int unsigned CTL_USED = CTL_LOOP + 1;

  // change flag positions inside the status byte
  localparam int unsigned CHG_CTS = 0;
  localparam int unsigned CHG_DSR = 1;
  localparam int unsigned CHG_RI  = 2;
  localparam int unsigned CHG_DCD = 3;

  // line state, ordered as status bits 7..4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_t;

  localparam line_t LINES_RESET = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};

  function automatic line_t map_lines(input logic [CTL_USED-1:0] ctl,
                                      input logic cts_ext,
                                      input logic ri_ext);
    line_t l;
    if (ctl[CTL_LOOP]) begin
      l.cts = ctl[CTL_RTS];
      l.dsr = ctl[CTL_DTR];
      l.ri  = ctl[CTL_OUT1];
      l.dcd = ctl[CTL_OUT2];
    end else begin
      l.cts = cts_ext;
      l.dsr = 1'b1;
      l.ri  = ri_ext;
      l.dcd = 1'b1;
    end
    return l;
  endfunction

endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (!rst_n)
            stg_q[s] <= '0;
          else if (s == 0)
            stg_q[s] <= d;
          else
            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mcs_ctl_reg.sv
module mcs_ctl_reg
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctl_q
);

  localparam logic [BYTE_W-1:0] KEEP_MASK = BYTE_W'((1 << CTL_USED) - 1);

  logic [CTL_USED-1:0] ctl_r;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_r <= '0;
    else if (wr_en)
      ctl_r <= wr_data[CTL_USED-1:0];
  end

  assign ctl_q = {{(BYTE_W-CTL_USED){1'b0}}, ctl_r};

  AST_CTL_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctl_q == ($past(wr_data) & KEEP_MASK)); // R1

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q)); // R1

endmodule

// File: rtl/mcs_delta.sv
module mcs_delta
  import mcs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  line_t                lines_d,
  input  logic                 rd_en,
  output line_t                lines_q,
  output logic [NUM_LINES-1:0] delta_q
);

  logic [NUM_LINES-1:0] det;
  logic [NUM_LINES-1:0] delta_n;

  always_comb begin
    det          = '0;
    det[CHG_CTS] = lines_d.cts ^ lines_q.cts;
    det[CHG_DSR] = lines_d.dsr ^ lines_q.dsr;
    det[CHG_DCD] = lines_d.dcd ^ lines_q.dcd;
    det[CHG_RI]  = lines_q.ri & ~lines_d.ri;   // trailing edge only
    delta_n      = (rd_en ? '0 : delta_q) | det;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_q <= LINES_RESET;
      delta_q <= '0;
    end else begin
      lines_q <= lines_d;
      delta_q <= delta_n;
    end
  end

  AST_CTS_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lines_q.cts) |-> delta_q[CHG_CTS]); // R5

  AST_DCD_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lines_q.dcd) |-> delta_q[CHG_DCD]); // R5

  AST_RI_FALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lines_q.ri) |-> delta_q[CHG_RI]); // R6

  AST_RI_RISE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lines_q.ri) && !$past(delta_q[CHG_RI])) |-> !delta_q[CHG_RI]); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (delta_q & $past(delta_q)) == $past(delta_q)); // R7

  AST_QUIET_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && lines_d == lines_q) |=> delta_q == '0); // R8

endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import mcs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [BYTE_W-1:0] ctl_wr_data,
  output logic [BYTE_W-1:0] ctl_q,
  input  logic              sts_rd_en,
  output logic [BYTE_W-1:0] sts_q,
  output logic              sts_change,
  input  logic              modem_cts_i,
  input  logic              modem_ri_i
);

  localparam int unsigned EXT_W = 2;

  logic [EXT_W-1:0]     ext_sync;
  line_t                lines_d;
  line_t                lines_q;
  logic [NUM_LINES-1:0] delta_q;

  mcs_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .ctl_q   (ctl_q)
  );

  mcs_sync #(.WIDTH(EXT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({modem_ri_i, modem_cts_i}),
    .q     (ext_sync)
  );

  assign lines_d = map_lines(ctl_q[CTL_USED-1:0], ext_sync[0], ext_sync[1]);

  mcs_delta u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_d (lines_d),
    .rd_en   (sts_rd_en),
    .lines_q (lines_q),
    .delta_q (delta_q)
  );

  assign sts_q      = {lines_q, delta_q};
  assign sts_change = |delta_q;

  AST_LOOP_MAPPING: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_LOOP] |=> sts_q[7:4] == {$past(ctl_q[CTL_OUT2]), $past(ctl_q[CTL_OUT1]),
                                       $past(ctl_q[CTL_DTR]),  $past(ctl_q[CTL_RTS])}); // R3

  AST_NOLOOP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[CTL_LOOP] |=> (sts_q[7] && sts_q[5])); // R4

  AST_CHANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sts_change == (sts_q[3:0] != 4'h0)); // R9

endmodule

// File: tb/modem_ctl_status_tb_top.sv
module modem_ctl_status_tb_top;

  localparam int unsigned SYNC  = 2;
  localparam int unsigned SETTLE = SYNC + 4;
  localparam int unsigned NVEC  = 14;

  // {wr, wdata[8], cts, ri, rd, exp_ctl[8], exp_sts[8], exp_chg}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'hB1, 1'b1}, // CTS rises outside loopback
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'hF0, 1'b0}, // RI rises: no flag
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'hB4, 1'b1}, // RI falls: flag
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h1F, 8'hF0, 1'b0}, // loopback, all outputs on
    {1'b1, 8'h10, 1'b0, 1'b0, 1'b1, 8'h10, 8'h0F, 1'b1}, // all lines drop
    {1'b1, 8'h13, 1'b0, 1'b0, 1'b1, 8'h13, 8'h33, 1'b1}, // DTR, RTS
    {1'b1, 8'h1C, 1'b0, 1'b0, 1'b1, 8'h1C, 8'hCB, 1'b1}, // OUT1, OUT2
    {1'b1, 8'hE0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hF3, 1'b1}, // upper bits dropped
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'hA7, 1'b1}, // sticky plus new flags
    {1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 8'h0F, 8'hA0, 1'b0}, // outputs only, no loop
    {1'b1, 8'h10, 1'b0, 1'b0, 1'b1, 8'h10, 8'h0A, 1'b1}, // enter loopback
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'hAA, 1'b1}, // leave loopback
    {1'b1, 8'h10, 1'b1, 1'b1, 1'b1, 8'h10, 8'h0A, 1'b1}, // ext high ignored
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h10, 8'h00, 1'b0}  // ext toggles ignored
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr_en = 1'b0;
  logic [7:0] ctl_wr_data = '0;
  logic [7:0] ctl_q;
  logic       sts_rd_en = 1'b0;
  logic [7:0] sts_q;
  logic       sts_change;
  logic       modem_cts_i = 1'b0;
  logic       modem_ri_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  modem_ctl_status #(.SYNC_STAGES(SYNC)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .ctl_q       (ctl_q),
    .sts_rd_en   (sts_rd_en),
    .sts_q       (sts_q),
    .sts_change  (sts_change),
    .modem_cts_i (modem_cts_i),
    .modem_ri_i  (modem_ri_i)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en   = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp_before);
    @(negedge clk);
    sts_rd_en = 1'b1;
    #1 check("R8 read shows pre-clear value", sts_q, exp_before);
    @(negedge clk);
    sts_rd_en = 1'b0;
    check("R8 flags cleared by read", {4'h0, sts_q[3:0]}, 8'h00);
    check("R9 change flag low after read", {7'h0, sts_change}, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 reset ctl", ctl_q, 8'h00);
    check("R2 reset sts", sts_q, 8'hA0);
    check("R2 reset change", {7'h0, sts_change}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [28:0] v;
      v = VEC[i];
      modem_cts_i = v[19];
      modem_ri_i  = v[18];
      if (v[28]) do_write(v[27:20]);
      repeat (SETTLE) @(negedge clk);
      check($sformatf("R1 ctl vector %0d", i), ctl_q, v[16:9]);
      check($sformatf("R3/R4/R5/R6/R7 sts vector %0d", i), sts_q, v[8:1]);
      check($sformatf("R9 change vector %0d", i), {7'h0, sts_change}, {7'h0, v[0]});
      if (v[17]) do_read(v[8:1]);
    end

    // R4 latency: CTS from outside loopback lands after SYNC+1 edges
    do_write(8'h00);
    repeat (SETTLE) @(negedge clk);
    do_read(sts_q);
    modem_cts_i = 1'b1;
    repeat (SYNC) @(negedge clk);
    check("R4 cts not yet visible", {7'h0, sts_q[4]}, 8'h00);
    @(negedge clk);
    check("R4 cts visible after sync", {7'h0, sts_q[4]}, 8'h01);
    modem_cts_i = 1'b0;
    repeat (SETTLE) @(negedge clk);
    do_read(8'hA1);

    // R8 collision: change detected on the same edge as the read
    do_write(8'h10);
    repeat (SETTLE) @(negedge clk);
    do_read(sts_q);
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = 8'h12;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    sts_rd_en = 1'b1;
    @(negedge clk);
    sts_rd_en = 1'b0;
    check("R8 set wins over read clear", sts_q, 8'h11);
    check("R9 change after collision", {7'h0, sts_change}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule